// File: doc/BRIEF.md
# Delegated Debug Trigger Access Unit

This unit sits between a control-register access port and a small bank of debug trigger registers. Each trigger holds three data words and an info word. Machine software reaches them through a trigger index register and four direct registers. Supervisor and virtual-supervisor software reach the same state through a second level of indirection. A supervisor view of the trigger index is the very same register as the machine one. When a per-path window-select register holds the trigger window code, four indirect data registers on that path land on the three data words and the info word of the currently indexed trigger.

On the way through the lower-privilege paths, the unit hides or relocates privilege-enable fields in data word 1. It also hides the hypervisor match fields of data word 3. The positions of those fields depend on the trigger type held in data word 1. Writes through a masked path are read-modify-write in a single cycle: protected bits keep their stored values. Trigger matching is not part of this unit.

Register access codes on `acc_reg` are 0 machine index, 1..4 machine data1/data2/data3/info, 5 supervisor index, 6 supervisor window select, 7..10 supervisor indirect 1..4, 11 virtual-supervisor window select, and 12..15 virtual-supervisor indirect 1..4. Reads return on `acc_rdata` in the same cycle. Writes take effect at the next clock edge. The defaults are XLEN 32, four triggers, 12-bit window selects and a window code of 0x2A5.

Top module: `dtrig_access_unit`

## Requirements
- R1: Codes 0 and 5 access one shared trigger index register. A write through either code stores the low log2(NUM_TRIG) bits (2 bits by default), and a read through either code returns that value zero-extended.
- R2: While the supervisor window select (code 6) equals the window code, codes 7, 8, 9 and 10 read and write data word 1, data word 2, data word 3 and the info word of the indexed trigger.
- R3: While the virtual-supervisor window select (code 11) equals the window code, codes 12..15 map onto the same four words in the same order, independently of the supervisor window select.
- R4: On both indirect paths, the machine enable bit of data word 1 reads as 0, and a write leaves its stored value unchanged.
- R5: On the supervisor path, the VS and VU enable bits of data word 1 read as 0 and keep their stored values on write. The S and U bits are read and written directly.
- R6: On the virtual-supervisor path, the visible S bit reads and writes the stored VS bit, and the visible U bit reads and writes the stored VU bit. The visible VS and VU bits read as 0, and the stored S and U bits are left unchanged by a write.
- R7: On the virtual-supervisor path, data word 3 bits [31:23] (hypervisor value [31:26] and select [25:23]) read as 0 and keep their stored values on write. On the supervisor path, data word 3 is unmodified.
- R8: Data word 2 and the info word pass unmodified, for both read and write, on both indirect paths.
- R9: When a path's window select differs from the window code, that path's indirect registers read 0, and writes to them change no trigger state.
- R10: When the type field (data word 1 bits [31:28]) is neither 2 nor 6, no relocation takes place. On both indirect paths, bits 3, 4, 6, 11, 12, 23 and 24 of data word 1 read as 0 and keep their stored values on write, and all other bits pass.
- R11: Machine codes 1..4 give raw, unmasked access to the indexed trigger. All registers reset to 0.
- R12: Field positions are chosen per type. Type 2 has M=6, S=4, U=3, VS=12, VU=11. Type 6 has M=6, S=4, U=3, VS=24, VU=23.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access request this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_reg | input | 4 | Register access code |
| acc_wdata | input | XLEN | Write data |
| acc_rdata | output | XLEN | Read data (combinational, 0 when idle) |

## Verification
The assertions check on every cycle four things:
- writes through either index code land in the shared index;
- protected privilege bits and hypervisor fields stay put across a masked write;
- data word 2 and the info word take the written value;
- a write through a closed window leaves the selected trigger untouched.

Only the bench scenarios can show the following:
- the read-side views, including relocation of VS/VU into the S/U positions;
- the per-type field positions;
- the hiding for an unsupported type;
- that both paths map onto the trigger chosen by the current index.

// File: rtl/dtrig_pkg.sv
package dtrig_pkg;

  localparam logic [3:0] RC_MSEL   = 4'd0;
  localparam logic [3:0] RC_MD1    = 4'd1;
  localparam logic [3:0] RC_MINFO  = 4'd4;
  localparam logic [3:0] RC_SSEL   = 4'd5;
  localparam logic [3:0] RC_SWIN   = 4'd6;
  localparam logic [3:0] RC_SIND1  = 4'd7;
  localparam logic [3:0] RC_SIND4  = 4'd10;
  localparam logic [3:0] RC_VSWIN  = 4'd11;
  localparam logic [3:0] RC_VSIND1 = 4'd12;
  localparam logic [3:0] RC_VSIND4 = 4'd15;

  typedef enum logic [1:0] {
    PATH_M  = 2'd0,
    PATH_S  = 2'd1,
    PATH_VS = 2'd2
  } path_e;

  // word index: 0 data1, 1 data2, 2 data3, 3 info
  typedef logic [1:0] word_t;

  typedef struct packed {
    logic  is_sel;
    logic  is_swin;
    logic  is_vswin;
    logic  is_word;
    logic  hit;
    path_e path;
    word_t word;
  } acc_dec_t;

endpackage

// File: rtl/dtrig_decode.sv
module dtrig_decode
  import dtrig_pkg::*;
#(
  parameter int ISEL_W = 12,
  parameter logic [ISEL_W-1:0] WIN_CODE = 12'h2A5
) (
  input  logic [3:0]        acc_reg,
  input  logic [ISEL_W-1:0] s_win,
  input  logic [ISEL_W-1:0] vs_win,
  output acc_dec_t          dec
);

  logic s_open, vs_open;
  assign s_open  = (s_win == WIN_CODE);
  assign vs_open = (vs_win == WIN_CODE);

  always_comb begin
    dec          = '0;
    dec.path     = PATH_M;
    dec.is_sel   = (acc_reg == RC_MSEL) || (acc_reg == RC_SSEL);
    dec.is_swin  = (acc_reg == RC_SWIN);
    dec.is_vswin = (acc_reg == RC_VSWIN);
    if (acc_reg >= RC_MD1 && acc_reg <= RC_MINFO) begin
      dec.is_word = 1'b1;
      dec.hit     = 1'b1;
      dec.path    = PATH_M;
      dec.word    = word_t'(acc_reg - RC_MD1);
    end else if (acc_reg >= RC_SIND1 && acc_reg <= RC_SIND4) begin
      dec.is_word = 1'b1;
      dec.hit     = s_open;
      dec.path    = PATH_S;
      dec.word    = word_t'(acc_reg - RC_SIND1);
    end else if (acc_reg >= RC_VSIND1) begin
      dec.is_word = 1'b1;
      dec.hit     = vs_open;
      dec.path    = PATH_VS;
      dec.word    = word_t'(acc_reg - RC_VSIND1);
    end
  end

endmodule

// File: rtl/dtrig_bank.sv
module dtrig_bank #(
  parameter int XLEN     = 32,
  parameter int NUM_TRIG = 4,
  localparam int IDX_W   = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_we,
  input  logic [IDX_W-1:0] sel_wdata,
  input  logic             word_we,
  input  logic [1:0]       word_idx,
  input  logic [XLEN-1:0]  word_wdata,
  output logic [IDX_W-1:0] sel_q,
  output logic [XLEN-1:0]  cur_d1,
  output logic [XLEN-1:0]  cur_d2,
  output logic [XLEN-1:0]  cur_d3,
  output logic [XLEN-1:0]  cur_info
);

  logic [XLEN-1:0] d1_q   [NUM_TRIG];
  logic [XLEN-1:0] d2_q   [NUM_TRIG];
  logic [XLEN-1:0] d3_q   [NUM_TRIG];
  logic [XLEN-1:0] info_q [NUM_TRIG];

  always_ff @(posedge clk) begin
    if (!rst_n) sel_q <= '0;
    else if (sel_we) sel_q <= sel_wdata;
  end

  for (genvar t = 0; t < NUM_TRIG; t++) begin : g_trig
    logic hit_t;
    assign hit_t = word_we && (sel_q == IDX_W'(t));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        d1_q[t]   <= '0;
        d2_q[t]   <= '0;
        d3_q[t]   <= '0;
        info_q[t] <= '0;
      end else if (hit_t) begin
        case (word_idx)
          2'd0:    d1_q[t]   <= word_wdata;
          2'd1:    d2_q[t]   <= word_wdata;
          2'd2:    d3_q[t]   <= word_wdata;
          default: info_q[t] <= word_wdata;
        endcase
      end
    end
  end

  assign cur_d1   = d1_q[sel_q];
  assign cur_d2   = d2_q[sel_q];
  assign cur_d3   = d3_q[sel_q];
  assign cur_info = info_q[sel_q];

endmodule

// File: rtl/dtrig_view.sv
module dtrig_view
  import dtrig_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int TYPE_LSB = 28,
  parameter int TYPE_W   = 4,
  parameter int TYPE_A   = 2,
  parameter int TYPE_B   = 6,
  parameter int A_M = 6, parameter int A_S = 4, parameter int A_U = 3,
  parameter int A_VS = 12, parameter int A_VU = 11,
  parameter int B_M = 6, parameter int B_S = 4, parameter int B_U = 3,
  parameter int B_VS = 24, parameter int B_VU = 23,
  parameter int MHV_LSB = 26, parameter int MHV_W = 6,
  parameter int MHS_LSB = 23, parameter int MHS_W = 3
) (
  input  path_e           path,
  input  logic [XLEN-1:0] cur_d1,
  input  logic [XLEN-1:0] cur_d3,
  input  logic [XLEN-1:0] wdata,
  output logic [XLEN-1:0] view_d1,
  output logic [XLEN-1:0] view_d3,
  output logic [XLEN-1:0] merge_d1,
  output logic [XLEN-1:0] merge_d3,
  output logic [XLEN-1:0] prot_d1,
  output logic [XLEN-1:0] prot_d3
);

  function automatic logic [XLEN-1:0] fmask(input int lsb, input int w);
    logic [XLEN-1:0] r;
    r = '0;
    for (int i = 0; i < XLEN; i++)
      if (i >= lsb && i < lsb + w) r[i] = 1'b1;
    return r;
  endfunction

  // place bit `b` at the position given by mask `m`
  function automatic logic [XLEN-1:0] put(input logic b, input logic [XLEN-1:0] m);
    return b ? m : '0;
  endfunction

  localparam logic [XLEN-1:0] AM = fmask(A_M, 1), AS = fmask(A_S, 1), AU = fmask(A_U, 1);
  localparam logic [XLEN-1:0] AVS = fmask(A_VS, 1), AVU = fmask(A_VU, 1);
  localparam logic [XLEN-1:0] BM = fmask(B_M, 1), BS = fmask(B_S, 1), BU = fmask(B_U, 1);
  localparam logic [XLEN-1:0] BVS = fmask(B_VS, 1), BVU = fmask(B_VU, 1);
  localparam logic [XLEN-1:0] ALL_PRIV = AM | AS | AU | AVS | AVU | BM | BS | BU | BVS | BVU;
  localparam logic [XLEN-1:0] MH_MASK = fmask(MHV_LSB, MHV_W) | fmask(MHS_LSB, MHS_W);

  logic [TYPE_W-1:0] type_f;
  logic              known;
  logic [XLEN-1:0]   m_m, s_m, u_m, vs_m, vu_m;

  assign type_f = cur_d1[TYPE_LSB +: TYPE_W];

  always_comb begin
    known = 1'b1;
    m_m = AM; s_m = AS; u_m = AU; vs_m = AVS; vu_m = AVU;
    if (type_f == TYPE_W'(TYPE_B)) begin
      m_m = BM; s_m = BS; u_m = BU; vs_m = BVS; vu_m = BVU;
    end else if (type_f != TYPE_W'(TYPE_A)) begin
      known = 1'b0;
    end
  end

  logic [XLEN-1:0] s_hide, vs_hide;
  logic [XLEN-1:0] vs_reloc_rd, vs_reloc_wr;
  assign s_hide      = m_m | vs_m | vu_m;
  assign vs_hide     = m_m | vs_m | vu_m | s_m | u_m;
  assign vs_reloc_rd = put(|(cur_d1 & vs_m), s_m) | put(|(cur_d1 & vu_m), u_m);
  assign vs_reloc_wr = put(|(wdata & s_m), vs_m) | put(|(wdata & u_m), vu_m);

  always_comb begin
    view_d1  = cur_d1;
    merge_d1 = wdata;
    prot_d1  = '0;
    if (path != PATH_M) begin
      if (!known) begin
        prot_d1  = ALL_PRIV;
        view_d1  = cur_d1 & ~ALL_PRIV;
        merge_d1 = (cur_d1 & ALL_PRIV) | (wdata & ~ALL_PRIV);
      end else if (path == PATH_S) begin
        prot_d1  = s_hide;
        view_d1  = cur_d1 & ~s_hide;
        merge_d1 = (cur_d1 & s_hide) | (wdata & ~s_hide);
      end else begin
        prot_d1  = m_m | s_m | u_m;
        view_d1  = (cur_d1 & ~vs_hide) | vs_reloc_rd;
        merge_d1 = (cur_d1 & (m_m | s_m | u_m)) | (wdata & ~vs_hide) | vs_reloc_wr;
      end
    end
  end

  always_comb begin
    view_d3  = cur_d3;
    merge_d3 = wdata;
    prot_d3  = '0;
    if (path == PATH_VS) begin
      prot_d3  = MH_MASK;
      view_d3  = cur_d3 & ~MH_MASK;
      merge_d3 = (cur_d3 & MH_MASK) | (wdata & ~MH_MASK);
    end
  end

endmodule

// File: rtl/dtrig_access_unit.sv
module dtrig_access_unit
  import dtrig_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int NUM_TRIG = 4,
  parameter int ISEL_W   = 12,
  parameter logic [ISEL_W-1:0] WIN_CODE = 12'h2A5,
  parameter int TYPE_LSB = 28,
  parameter int TYPE_W   = 4,
  parameter int TYPE_A   = 2,
  parameter int TYPE_B   = 6,
  parameter int A_M = 6, parameter int A_S = 4, parameter int A_U = 3,
  parameter int A_VS = 12, parameter int A_VU = 11,
  parameter int B_M = 6, parameter int B_S = 4, parameter int B_U = 3,
  parameter int B_VS = 24, parameter int B_VU = 23,
  parameter int MHV_LSB = 26, parameter int MHV_W = 6,
  parameter int MHS_LSB = 23, parameter int MHS_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            acc_valid,
  input  logic            acc_write,
  input  logic [3:0]      acc_reg,
  input  logic [XLEN-1:0] acc_wdata,
  output logic [XLEN-1:0] acc_rdata
);

  localparam int IDX_W = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1;

  logic [ISEL_W-1:0] s_win_q, vs_win_q;
  acc_dec_t          dec;
  logic [IDX_W-1:0]  sel_q;
  logic [XLEN-1:0]   cur_d1, cur_d2, cur_d3, cur_info;
  logic [XLEN-1:0]   view_d1, view_d3, merge_d1, merge_d3, prot_d1, prot_d3;
  logic [XLEN-1:0]   word_wdata;
  logic              wr, sel_we, word_we, miss_wr;

  dtrig_decode #(.ISEL_W(ISEL_W), .WIN_CODE(WIN_CODE)) u_dec (
    .acc_reg(acc_reg), .s_win(s_win_q), .vs_win(vs_win_q), .dec(dec)
  );

  assign wr      = acc_valid && acc_write;
  assign sel_we  = wr && dec.is_sel;
  assign word_we = wr && dec.is_word && dec.hit;
  assign miss_wr = wr && dec.is_word && !dec.hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s_win_q  <= '0;
      vs_win_q <= '0;
    end else begin
      if (wr && dec.is_swin)  s_win_q  <= acc_wdata[ISEL_W-1:0];
      if (wr && dec.is_vswin) vs_win_q <= acc_wdata[ISEL_W-1:0];
    end
  end

  dtrig_view #(
    .XLEN(XLEN), .TYPE_LSB(TYPE_LSB), .TYPE_W(TYPE_W), .TYPE_A(TYPE_A), .TYPE_B(TYPE_B),
    .A_M(A_M), .A_S(A_S), .A_U(A_U), .A_VS(A_VS), .A_VU(A_VU),
    .B_M(B_M), .B_S(B_S), .B_U(B_U), .B_VS(B_VS), .B_VU(B_VU),
    .MHV_LSB(MHV_LSB), .MHV_W(MHV_W), .MHS_LSB(MHS_LSB), .MHS_W(MHS_W)
  ) u_view (
    .path(dec.path), .cur_d1(cur_d1), .cur_d3(cur_d3), .wdata(acc_wdata),
    .view_d1(view_d1), .view_d3(view_d3), .merge_d1(merge_d1), .merge_d3(merge_d3),
    .prot_d1(prot_d1), .prot_d3(prot_d3)
  );

  always_comb begin
    case (dec.word)
      2'd0:    word_wdata = merge_d1;
      2'd2:    word_wdata = merge_d3;
      default: word_wdata = acc_wdata;
    endcase
  end

  dtrig_bank #(.XLEN(XLEN), .NUM_TRIG(NUM_TRIG)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .sel_we(sel_we), .sel_wdata(acc_wdata[IDX_W-1:0]),
    .word_we(word_we), .word_idx(dec.word), .word_wdata(word_wdata),
    .sel_q(sel_q), .cur_d1(cur_d1), .cur_d2(cur_d2), .cur_d3(cur_d3), .cur_info(cur_info)
  );

  always_comb begin
    acc_rdata = '0;
    if (acc_valid) begin
      if (dec.is_sel)        acc_rdata = XLEN'(sel_q);
      else if (dec.is_swin)  acc_rdata = XLEN'(s_win_q);
      else if (dec.is_vswin) acc_rdata = XLEN'(vs_win_q);
      else if (dec.is_word && dec.hit) begin
        case (dec.word)
          2'd0:    acc_rdata = view_d1;
          2'd1:    acc_rdata = cur_d2;
          2'd2:    acc_rdata = view_d3;
          default: acc_rdata = cur_info;
        endcase
      end
    end
  end

  AST_SEL_SHARED: assert property (@(posedge clk) disable iff (!rst_n)
    sel_we |=> sel_q == $past(acc_wdata[IDX_W-1:0])); // R1

  AST_PRIV_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (word_we && dec.word == 2'd0) |=> ((cur_d1 ^ $past(cur_d1)) & $past(prot_d1)) == '0); // R4

  AST_MH_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (word_we && dec.word == 2'd2) |=> ((cur_d3 ^ $past(cur_d3)) & $past(prot_d3)) == '0); // R7

  AST_PASS_WORDS: assert property (@(posedge clk) disable iff (!rst_n)
    (word_we && dec.word == 2'd1) |=> cur_d2 == $past(acc_wdata)); // R8

  AST_PASS_INFO: assert property (@(posedge clk) disable iff (!rst_n)
    (word_we && dec.word == 2'd3) |=> cur_info == $past(acc_wdata)); // R8

  AST_CLOSED_WIN: assert property (@(posedge clk) disable iff (!rst_n)
    miss_wr |=> $stable({cur_d1, cur_d2, cur_d3, cur_info})); // R9

endmodule

// File: tb/sim_dtrig_access_unit.sv
module sim_dtrig_access_unit;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] WIN = 32'h2A5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0, acc_write = 1'b0;
  logic [3:0]  acc_reg = '0;
  logic [31:0] acc_wdata = '0;
  logic [31:0] acc_rdata;
  int total = 0, bad = 0;
  bit done = 1'b0;

  dtrig_access_unit u0 (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_reg(acc_reg), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%08h exp=%08h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] r, input logic [31:0] d);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = 1'b1; acc_reg = r; acc_wdata = d;
    @(posedge clk); #1;
    acc_valid = 1'b0; acc_write = 1'b0;
  endtask

  task automatic rd(input logic [3:0] r, output logic [31:0] d);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = 1'b0; acc_reg = r;
    #1 d = acc_rdata;
    acc_valid = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(4'd0, v); chk("R11 reset index", v, 0);
    rd(4'd1, v); chk("R11 reset data1", v, 0);
    rd(4'd6, v); chk("R11 reset swin", v, 0);
  endtask

  task automatic t_select();
    logic [31:0] v;
    wr(4'd5, 32'd2); rd(4'd0, v); chk("R1 sup->mach index", v, 2);
    wr(4'd0, 32'd7); rd(4'd5, v); chk("R1 mach->sup index low bits", v, 3);
  endtask

  task automatic t_map();
    logic [31:0] v;
    wr(4'd0, 1);
    wr(4'd1, 32'h2000_1858); wr(4'd2, 32'h1111_2222);
    wr(4'd3, 32'hFFFF_0F0F); wr(4'd4, 32'h0000_00A5);
    wr(4'd6, WIN);
    rd(4'd8, v);  chk("R2 sind2->data2", v, 32'h1111_2222);
    rd(4'd9, v);  chk("R7 sind3 unmodified", v, 32'hFFFF_0F0F);
    rd(4'd10, v); chk("R8 sind4->info", v, 32'h0000_00A5);
    wr(4'd10, 32'h0BAD_F00D); rd(4'd4, v); chk("R8 info write pass", v, 32'h0BAD_F00D);
    wr(4'd0, 2);
    rd(4'd8, v);  chk("R2 follows index", v, 0);
    wr(4'd0, 1);
  endtask

  task automatic t_miss();
    logic [31:0] v;
    wr(4'd6, 32'h2A4);
    rd(4'd8, v); chk("R9 closed read zero", v, 0);
    wr(4'd8, 32'hDEAD_BEEF);
    rd(4'd2, v); chk("R9 closed write no effect", v, 32'h1111_2222);
    rd(4'd14, v); chk("R9 vs closed read zero", v, 0);
    wr(4'd6, WIN);
  endtask

  task automatic t_vs_words();
    logic [31:0] v;
    wr(4'd11, WIN);
    wr(4'd6, 32'h0);
    rd(4'd13, v); chk("R3 vsind2->data2", v, 32'h1111_2222);
    rd(4'd14, v); chk("R7 vs hides mh", v, 32'h007F_0F0F);
    wr(4'd14, 32'hFFFF_FFFF);
    rd(4'd3, v); chk("R7 vs keeps mh", v, 32'hFFFF_FFFF & (32'hFF80_0000 | 32'h007F_FFFF));
    wr(4'd3, 32'h0000_0000); wr(4'd14, 32'hFFFF_FFFF);
    rd(4'd3, v); chk("R7 vs mh stays zero", v, 32'h007F_FFFF);
    wr(4'd6, WIN);
  endtask

  task automatic t_sup_d1();
    logic [31:0] v;
    wr(4'd1, 32'h2000_1858);
    rd(4'd7, v);  chk("R5 sup hides M/VS/VU", v, 32'h2000_0018);
    rd(4'd12, v); chk("R6 vs relocates", v, 32'h2000_0018);
    wr(4'd7, 32'h2000_0001);
    rd(4'd1, v);  chk("R4 sup write keeps M/VS/VU", v, 32'h2000_1841);
  endtask

  task automatic t_vs_d1();
    logic [31:0] v;
    wr(4'd1, 32'h2000_0818);
    rd(4'd12, v); chk("R6 vs U from VU", v, 32'h2000_0008);
    wr(4'd12, 32'h2000_1851);
    rd(4'd1, v);  chk("R6 vs write relocates", v, 32'h2000_1019);
  endtask

  task automatic t_type_b();
    logic [31:0] v;
    wr(4'd1, 32'h6180_0040);
    rd(4'd7, v);  chk("R12 typeB sup hides", v, 32'h6000_0000);
    rd(4'd12, v); chk("R12 typeB vs relocates", v, 32'h6000_0018);
  endtask

  task automatic t_unknown();
    logic [31:0] v;
    wr(4'd1, 32'h3180_1859);
    rd(4'd7, v);  chk("R10 unknown sup", v, 32'h3000_0001);
    rd(4'd12, v); chk("R10 unknown vs", v, 32'h3000_0001);
    wr(4'd7, 32'h3000_0000);
    rd(4'd1, v);  chk("R10 unknown write keeps", v, 32'h3180_1858);
    rd(4'd1, v);  chk("R11 machine raw", v, 32'h3180_1858);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog got=%0d exp=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_select();
    t_map();
    t_miss();
    t_vs_words();
    t_sup_d1();
    t_vs_d1();
    t_type_b();
    t_unknown();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule